// File: doc/BRIEF.md
# Power-Register Mailbox Engine

This block is the service side of a power-control mailbox. Once a message has landed in the mailbox, the surrounding logic hands it over with a one-cycle `start` strobe. The strobe carries a command byte, a 4-bit sub-command, a byte count and the raw contents of the write buffer. The engine checks the message and unpacks the list of 16-bit register addresses from the payload. It then works through the list against a local file of 8-bit registers, one item per clock.

Three operations are supported:

- **Write:** stores a list of bytes.
- **Read:** returns a list of register values, byte by byte, into a response buffer.
- **Read-modify-write:** updates only the bits of one register that a mask selects.

Every message ends with a single-cycle `done` pulse that carries an error flag and an error code. A message that fails its checks leaves every register untouched.

Top module: `pwr_mailbox_engine`

## Requirements
- R1: After reset the engine is idle (`busy` and `done` low), and every register of the file reads as 0x00.
- R2: Command byte 0xFF with sub-command 0 writes N registers. The size must be 3N. Payload bytes 2i (low) and 2i+1 (high) hold the address of item i, and payload byte 2N+i holds the data for item i.
- R3: Command byte 0xFF with sub-command 1 reads N registers. The size must be 2N, and addresses are packed as in R2. The value of item i is returned in response byte i. All other response bytes read 0x00.
- R4: Command byte 0xFF with sub-command 2 performs a read-modify-write. The size must be 4. Payload bytes 0 and 1 hold the address, byte 2 holds the value and byte 3 holds the mask. The register becomes (old AND NOT mask) OR (value AND mask).
- R5: Items are applied in list order, so when one write message names the same address twice, the later data byte remains.
- R6: The message fails with error code 3 and no register changes in any of these cases:
  - the size is zero;
  - the size is not an exact multiple of the item size (3 for write, 2 for read);
  - the item count exceeds five;
  - a read-modify-write size is other than 4.
- R7: A command byte other than 0xFF fails with error code 1. A sub-command other than 0, 1 or 2 fails with error code 2. In both cases no register changes.
- R8: If any listed address is 256 or above, the whole message fails with error code 4 before anything is written. Items earlier in the list that name valid addresses stay unchanged too.
- R9: Every accepted message raises `busy` on the next cycle and ends with `done` high for exactly one cycle, after which `busy` is low. While `done` is high, `err` is 0 with code 0 on success, and `err` is 1 with a nonzero code on failure.
- R10: Messages of exactly five items (write size 15, read size 10) are accepted and handle all five registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle strobe handing over a message; accepted only while idle |
| cmd | input | 8 | Command byte of the message |
| sub | input | 4 | Sub-command |
| size | input | 8 | Payload length in bytes |
| wbuf | input | 128 | Write buffer, byte k in bits 8k+7:8k |
| busy | output | 1 | Message in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Error flag, valid with `done` |
| err_code | output | 8 | Error code, valid with `done` (0 ok, 1 command, 2 sub-command, 3 size, 4 address) |
| rbuf | output | 128 | Response buffer, byte k in bits 8k+7:8k |

## Verification
The bench goes after these corner cases:

- **Duplicate address in one write.** An engine that applied items out of order, or in parallel, would leave the earlier byte behind.
- **Out-of-range address placed after a valid item.** An engine that checked addresses while it wrote would already have changed the first register.
- **Size values just outside the legal set.** These are a zero size, 4 for a write, 12 for a read and 3 for a read-modify-write. A sloppy divider would turn them into a short or an over-long list and write garbage.
- **Five-item messages.** These catch an off-by-one in the item counter.
- **Masked update with a mask that mixes ones and zeros.** This exposes an inverted or missing mask.
- **Read-back of unused response bytes.** This catches a buffer that is not cleared between messages.

// File: rtl/pwr_mailbox_engine.sv
module pwr_mailbox_engine #(
  parameter int NREG = 256,
  parameter int MAXN = 5,
  parameter int BUF_BYTES = 16,
  parameter logic [7:0] CMD_CODE = 8'hFF
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start,
  input  logic [7:0]             cmd,
  input  logic [3:0]             sub,
  input  logic [7:0]             size,
  input  logic [BUF_BYTES*8-1:0] wbuf,
  output logic                   busy,
  output logic                   done,
  output logic                   err,
  output logic [7:0]             err_code,
  output logic [BUF_BYTES*8-1:0] rbuf
);
  localparam int RW = $clog2(NREG);
  localparam int PW = $clog2(BUF_BYTES);
  localparam logic [7:0]  MAXN8  = 8'(MAXN);
  localparam logic [15:0] NREG16 = 16'(NREG);
  localparam logic [3:0]  SUB_WR = 4'd0, SUB_RD = 4'd1, SUB_RMW = 4'd2;
  localparam logic [7:0]  E_NONE = 8'd0, E_CMD = 8'd1, E_SUB = 8'd2, E_SIZE = 8'd3, E_ADDR = 8'd4;

  typedef enum logic [1:0] {S_IDLE, S_CHECK, S_RUN, S_FIN} state_t;
  state_t st;

  logic [7:0] cmd_q, size_q, n_q, idx, code_q, n_calc, code_calc;
  logic [3:0] sub_q;
  logic       err_q, touched;
  logic [7:0] pay    [BUF_BYTES];
  logic [7:0] rbuf_q [BUF_BYTES];
  logic [7:0] regs   [NREG];

  // message validation, evaluated in the cycle after acceptance
  always_comb begin
    n_calc = 8'd0;
    code_calc = E_NONE;
    if (cmd_q != CMD_CODE) code_calc = E_CMD;
    else begin
      case (sub_q)
        SUB_WR:
          if (size_q == 8'd0 || size_q % 8'd3 != 8'd0 || size_q / 8'd3 > MAXN8) code_calc = E_SIZE;
          else n_calc = size_q / 8'd3;
        SUB_RD:
          if (size_q == 8'd0 || size_q % 8'd2 != 8'd0 || size_q / 8'd2 > MAXN8) code_calc = E_SIZE;
          else n_calc = size_q / 8'd2;
        SUB_RMW:
          if (size_q != 8'd4) code_calc = E_SIZE;
          else n_calc = 8'd1;
        default: code_calc = E_SUB;
      endcase
    end
    if (code_calc == E_NONE) begin
      for (int i = 0; i < MAXN; i++) begin
        if (8'(i) < n_calc && {pay[2*i+1], pay[2*i]} >= NREG16) code_calc = E_ADDR;
      end
    end
  end

  logic [PW-1:0] ia_lo, ia_hi, id_data, ir;
  logic [15:0]   cur_addr;
  logic [RW-1:0] ra;
  logic          wr_en;
  logic [7:0]    wr_data;

  assign ia_lo    = PW'({idx, 1'b0});
  assign ia_hi    = PW'({idx, 1'b1});
  assign id_data  = PW'({n_q, 1'b0} + idx);
  assign ir       = PW'(idx);
  assign cur_addr = {pay[ia_hi], pay[ia_lo]};
  assign ra       = cur_addr[RW-1:0];
  assign wr_en    = (st == S_RUN) && (sub_q != SUB_RD);
  assign wr_data  = (sub_q == SUB_RMW) ? ((regs[ra] & ~pay[3]) | (pay[2] & pay[3]))
                                       : pay[id_data];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      cmd_q <= '0; sub_q <= '0; size_q <= '0;
      n_q <= '0; idx <= '0; err_q <= 1'b0; code_q <= E_NONE; touched <= 1'b0;
      for (int i = 0; i < BUF_BYTES; i++) begin
        pay[i] <= '0;
        rbuf_q[i] <= '0;
      end
    end else begin
      case (st)
        S_IDLE:
          if (start) begin
            cmd_q <= cmd; sub_q <= sub; size_q <= size;
            touched <= 1'b0;
            for (int i = 0; i < BUF_BYTES; i++) begin
              pay[i] <= wbuf[8*i +: 8];
              rbuf_q[i] <= '0;
            end
            st <= S_CHECK;
          end
        S_CHECK: begin
          idx <= '0;
          n_q <= n_calc;
          err_q <= (code_calc != E_NONE);
          code_q <= code_calc;
          st <= (code_calc != E_NONE) ? S_FIN : S_RUN;
        end
        S_RUN: begin
          if (sub_q == SUB_RD) rbuf_q[ir] <= regs[ra];
          if (wr_en) touched <= 1'b1;
          idx <= idx + 8'd1;
          if (idx == n_q - 8'd1) st <= S_FIN;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else if (wr_en) begin
      regs[ra] <= wr_data;
    end
  end

  assign busy     = (st != S_IDLE);
  assign done     = (st == S_FIN);
  assign err      = err_q;
  assign err_code = code_q;

  for (genvar g = 0; g < BUF_BYTES; g++) begin : g_rbuf
    assign rbuf[8*g +: 8] = rbuf_q[g];
  end

  p_accept_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !busy));
  p_ok_code_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !err) |-> (err_code == E_NONE));
  p_err_code_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && err) |-> (err_code != E_NONE));
  p_no_write_on_err_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && err) |-> !touched);
  p_addr_in_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (cur_addr < NREG16));
endmodule

// File: tb/pwr_mailbox_engine_bench.sv
module pwr_mailbox_engine_bench;
  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [7:0] cmd = '0, size = '0;
  logic [3:0] sub = '0;
  logic [127:0] wbuf = '0;
  logic busy, done, err;
  logic [7:0] err_code;
  logic [127:0] rbuf;

  int n_chk = 0, n_fail = 0;
  logic [7:0] pb [16];
  logic [7:0] mdl [256];
  logic       r_err;
  logic [7:0] r_code;
  logic [7:0] r_rb [16];

  always #2.5 clk = ~clk;

  pwr_mailbox_engine u_pwr_mailbox_engine (
    .clk(clk), .rst_n(rst_n), .start(start), .cmd(cmd), .sub(sub), .size(size),
    .wbuf(wbuf), .busy(busy), .done(done), .err(err), .err_code(err_code), .rbuf(rbuf));

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic clear_pb();
    for (int i = 0; i < 16; i++) pb[i] = 8'h00;
  endtask

  task automatic put_addr(input int i, input logic [15:0] a);
    pb[2*i] = a[7:0];
    pb[2*i+1] = a[15:8];
  endtask

  task automatic send(input logic [7:0] c, input logic [3:0] s, input logic [7:0] sz);
    int w;
    @(negedge clk);
    cmd = c; sub = s; size = sz;
    for (int i = 0; i < 16; i++) wbuf[8*i +: 8] = pb[i];
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R9", "busy after accept", busy, 1);
    w = 0;
    while (!done && w < 50) begin
      @(negedge clk);
      w++;
    end
    chk(done == 1'b1, "R9", "done seen", done, 1);
    r_err = err;
    r_code = err_code;
    for (int i = 0; i < 16; i++) r_rb[i] = rbuf[8*i +: 8];
    @(negedge clk);
    chk(!done && !busy, "R9", "done one cycle then idle", {done, busy}, 0);
  endtask

  task automatic read_list(input int n, input logic [15:0] a [5], input string req);
    clear_pb();
    for (int i = 0; i < n; i++) put_addr(i, a[i]);
    send(8'hFF, 4'd1, 8'(2*n));
    chk(r_err == 1'b0 && r_code == 8'd0, req, "read status", {r_err, r_code}, 0);
    for (int i = 0; i < 16; i++) begin
      if (i < n) chk(r_rb[i] == mdl[a[i][7:0]], req, "read byte", r_rb[i], mdl[a[i][7:0]]);
      else chk(r_rb[i] == 8'h00, "R3", "unused response byte", r_rb[i], 0);
    end
  endtask

  task automatic write_list(input int n, input logic [15:0] a [5], input logic [7:0] d [5], input string req);
    clear_pb();
    for (int i = 0; i < n; i++) begin
      put_addr(i, a[i]);
      pb[2*n+i] = d[i];
    end
    send(8'hFF, 4'd0, 8'(3*n));
    chk(r_err == 1'b0 && r_code == 8'd0, req, "write status", {r_err, r_code}, 0);
    for (int i = 0; i < n; i++) mdl[a[i][7:0]] = d[i];
  endtask

  task automatic expect_err(input logic [7:0] c, input logic [3:0] s, input logic [7:0] sz,
                            input logic [7:0] code, input string req);
    send(c, s, sz);
    chk(r_err == 1'b1 && r_code == code, req, "error code", {r_err, r_code}, {1'b1, code});
  endtask

  task automatic t_reset();
    logic [15:0] a [5] = '{16'd0, 16'd1, 16'd2, 16'd255, 16'd128};
    chk(busy == 1'b0 && done == 1'b0, "R1", "idle after reset", {busy, done}, 0);
    read_list(5, a, "R1");
  endtask

  task automatic t_write_read();
    logic [15:0] a [5] = '{16'h0012, 16'h0034, 16'h0056, 16'h0, 16'h0};
    logic [7:0]  d [5] = '{8'hA1, 8'hB2, 8'hC3, 8'h0, 8'h0};
    logic [15:0] b [5] = '{16'h0056, 16'h0012, 16'h0034, 16'h0, 16'h0};
    write_list(3, a, d, "R2");
    read_list(3, b, "R3");
  endtask

  task automatic t_five();
    logic [15:0] a [5] = '{16'd200, 16'd201, 16'd7, 16'd255, 16'd0};
    logic [7:0]  d [5] = '{8'h11, 8'h22, 8'h33, 8'h44, 8'h55};
    write_list(5, a, d, "R10");
    read_list(5, a, "R10");
  endtask

  task automatic t_dup();
    logic [15:0] a [5] = '{16'd10, 16'd10, 16'd0, 16'd0, 16'd0};
    logic [7:0]  d [5] = '{8'h11, 8'h22, 8'h0, 8'h0, 8'h0};
    write_list(2, a, d, "R5");
    chk(mdl[10] == 8'h22, "R5", "model later wins", mdl[10], 8'h22);
    read_list(1, a, "R5");
  endtask

  task automatic t_rmw();
    logic [15:0] a [5] = '{16'h0020, 16'h0, 16'h0, 16'h0, 16'h0};
    logic [7:0]  d [5] = '{8'hA5, 8'h0, 8'h0, 8'h0, 8'h0};
    write_list(1, a, d, "R4");
    clear_pb();
    put_addr(0, 16'h0020);
    pb[2] = 8'h5A;
    pb[3] = 8'h0F;
    send(8'hFF, 4'd2, 8'd4);
    chk(r_err == 1'b0, "R4", "rmw status", r_err, 0);
    mdl[8'h20] = (8'hA5 & ~8'h0F) | (8'h5A & 8'h0F);
    read_list(1, a, "R4");
  endtask

  task automatic t_size_err();
    logic [15:0] a [5] = '{16'd40, 16'd41, 16'd42, 16'd43, 16'd44};
    clear_pb();
    for (int i = 0; i < 5; i++) put_addr(i, a[i]);
    pb[10] = 8'hEE; pb[11] = 8'hEE; pb[12] = 8'hEE;
    expect_err(8'hFF, 4'd0, 8'd4,  8'd3, "R6");
    expect_err(8'hFF, 4'd0, 8'd18, 8'd3, "R6");
    expect_err(8'hFF, 4'd0, 8'd0,  8'd3, "R6");
    expect_err(8'hFF, 4'd1, 8'd0,  8'd3, "R6");
    expect_err(8'hFF, 4'd1, 8'd12, 8'd3, "R6");
    expect_err(8'hFF, 4'd1, 8'd3,  8'd3, "R6");
    expect_err(8'hFF, 4'd2, 8'd3,  8'd3, "R6");
    read_list(5, a, "R6");
  endtask

  task automatic t_cmd_err();
    logic [15:0] a [5] = '{16'd50, 16'd0, 16'd0, 16'd0, 16'd0};
    clear_pb();
    put_addr(0, 16'd50);
    pb[2] = 8'h77;
    expect_err(8'hF4, 4'd0, 8'd3, 8'd1, "R7");
    expect_err(8'hFF, 4'd5, 8'd3, 8'd2, "R7");
    expect_err(8'hFF, 4'd15, 8'd3, 8'd2, "R7");
    read_list(1, a, "R7");
  endtask

  task automatic t_addr_err();
    logic [15:0] a [5] = '{16'h0030, 16'h0100, 16'h0, 16'h0, 16'h0};
    clear_pb();
    put_addr(0, 16'h0030);
    put_addr(1, 16'h0100);
    pb[4] = 8'h99; pb[5] = 8'h98;
    expect_err(8'hFF, 4'd0, 8'd6, 8'd4, "R8");
    clear_pb();
    put_addr(0, 16'hFF31);
    pb[2] = 8'hFF; pb[3] = 8'hFF;
    expect_err(8'hFF, 4'd2, 8'd4, 8'd4, "R8");
    read_list(1, a, "R8");
    a[0] = 16'h0031;
    read_list(1, a, "R8");
  endtask

  initial begin
    #(5.0 * 200000);
    n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) mdl[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_write_read();
    t_five();
    t_dup();
    t_rmw();
    t_size_err();
    t_cmd_err();
    t_addr_err();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule